// File: doc/BRIEF.md
# Floating-Point Compare to Condition Flag

This block executes a floating-point compare instruction. It takes a 32-bit instruction word and two 64-bit operand values. It decodes the instruction, works out how the two operands relate, and tests that relation against an accepted-relation mask carried in the instruction. The one-bit outcome is written to one of eight condition flags. Single-precision compares use only the low 32 bits of each operand. Double-precision compares use all 64 bits.

The predicate is not taken from a list of named conditions. A 5-bit condition field is read as follows:

- Bit 0 picks the signaling form (1) or the quiet form (0).
- Bit 1 accepts less-than.
- Bit 2 accepts equal.
- Bit 3 accepts unordered.
- Bit 4 accepts not-equal, which means less-than or greater-than.

The relation is one of LT, EQ, GT or UN. Each compare also reports an invalid-operation indication, and it does so even when the result is false.

A two-state machine sequences the output:

- ST_IDLE: no result is presented. The transition `take` (in_valid high) moves to ST_EMIT. Otherwise the machine stays in ST_IDLE.
- ST_EMIT: the captured result is presented for one cycle. The transition `chain` (in_valid high again) stays in ST_EMIT. The transition `drain` (in_valid low) returns to ST_IDLE.

Top module: `fp_cmp_flag`

## Requirements
- R1: Only two opcodes count as a compare. Bits 31:20 must be 12'b0000_1100_0001 (single) or 12'b0000_1100_0010 (double), and bits 4:3 must be 2'b00. Any other word leaves out_wen low and out_invalid low.
- R2: out_wen is high in the cycle after the clock edge that sampled in_valid high with a compare word. In every other cycle out_wen is low.
- R3: out_flag_idx equals bits 2:0 of the instruction whose result is presented.
- R4: The condition field is bits 19:15, written cond below. out_result is 1 exactly when the computed relation is accepted:
  - LT is accepted by cond[1] or cond[4].
  - EQ is accepted by cond[2].
  - GT is accepted by cond[4].
  - UN is accepted by cond[3].
- R5: The relation is UN when either operand is a NaN. A NaN has an all-ones exponent and a non-zero fraction.
- R6: Positive zero and negative zero compare EQ.
- R7: Non-NaN operands are ordered by sign and then by magnitude, and the magnitude order is inverted when both operands are negative. Infinities order as the largest magnitudes.
- R8: When cond[0] is 1 (signaling form), out_invalid is 1 if either operand is any NaN.
- R9: When cond[0] is 0 (quiet form), out_invalid is 1 only if an operand is a signaling NaN. A signaling NaN is a NaN whose fraction MSB (the quiet bit) is 0.
- R10: In single precision (bits 31:20 = 12'b0000_1100_0001), bits 63:32 of both operands have no effect.
- R11: out_invalid is reported whether out_result is 0 or 1, and it is never high while out_wen is low.
- R12: After reset, out_wen, out_result, out_invalid and out_flag_idx are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 64 | First source operand value |
| opnd_b | input | 64 | Second source operand value |
| out_wen | output | 1 | Condition-flag write enable |
| out_flag_idx | output | 3 | Index of the condition flag to write |
| out_result | output | 1 | Compare outcome |
| out_invalid | output | 1 | Invalid-operation indication |

## Verification
The assertions assume that instr is held stable and well-defined whenever in_valid is high, and that in_valid is never X after reset. The stimulus drives all inputs at the falling clock edge and keeps in_valid low through reset. It keeps instr at a known value in every cycle, so the past-value checks on the instruction word always see defined bits. Non-compare words are deliberately mixed in, so the assertions tied to the opcode are checked under both outcomes.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int EXP_SGL = 8;
    localparam int MAN_SGL = 23;
    localparam int EXP_DBL = 11;
    localparam int MAN_DBL = 52;
    localparam int OPND_W  = 1 + EXP_DBL + MAN_DBL;
    localparam int IDX_W   = 3;

    localparam logic [11:0] OPC_SGL = 12'b0000_1100_0001;
    localparam logic [11:0] OPC_DBL = 12'b0000_1100_0010;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;

    // accept mask order: {un, gt, eq, lt}
    typedef struct packed {
        logic             is_cmp;
        logic             dbl;
        logic             sig;
        logic [3:0]       accept;
        logic [IDX_W-1:0] idx;
    } dec_t;

endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
    import fcmp_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [4:0] cond;
    logic       unused_src;

    assign cond       = instr[19:15];
    // source register numbers belong to the register file, not to this block
    assign unused_src = ^instr[14:5];

    always_comb begin
        dec.dbl    = (instr[31:20] == OPC_DBL);
        dec.is_cmp = ((instr[31:20] == OPC_SGL) || (instr[31:20] == OPC_DBL))
                     && (instr[4:3] == 2'b00);
        dec.sig    = cond[0];
        dec.accept = {cond[3], cond[4], cond[2], cond[1] | cond[4]};
        dec.idx    = instr[IDX_W-1:0];
    end

endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output rel_t         rel,
    output logic         any_nan,
    output logic         any_snan
);

    logic         sa, sb;
    logic [W-2:0] ma, mb;
    logic         nan_a, nan_b, snan_a, snan_b;
    logic         mag_lt;

    assign sa     = a[W-1];
    assign sb     = b[W-1];
    assign ma     = a[W-2:0];
    assign mb     = b[W-2:0];
    assign nan_a  = (&a[W-2 -: EXP_W]) && (|a[MAN_W-1:0]);
    assign nan_b  = (&b[W-2 -: EXP_W]) && (|b[MAN_W-1:0]);
    assign snan_a = nan_a && !a[MAN_W-1];
    assign snan_b = nan_b && !b[MAN_W-1];
    assign mag_lt = (ma < mb);

    assign any_nan  = nan_a | nan_b;
    assign any_snan = snan_a | snan_b;

    always_comb begin
        if (any_nan) begin
            rel = REL_UN;
        end else if ((ma == '0) && (mb == '0)) begin
            rel = REL_EQ;
        end else if (sa != sb) begin
            rel = sa ? REL_LT : REL_GT;
        end else if (ma == mb) begin
            rel = REL_EQ;
        end else if (sa) begin
            rel = mag_lt ? REL_GT : REL_LT;
        end else begin
            rel = mag_lt ? REL_LT : REL_GT;
        end
    end

endmodule

// File: rtl/fp_cmp_flag.sv
module fp_cmp_flag
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output logic              out_wen,
    output logic [IDX_W-1:0]  out_flag_idx,
    output logic              out_result,
    output logic              out_invalid
);

    localparam int N_PREC = 2;

    dec_t        dec;
    rel_t        rel_p  [N_PREC];
    logic        nan_p  [N_PREC];
    logic        snan_p [N_PREC];
    rel_t        rel_sel;
    logic        hit, inv;
    emit_state_t state, state_nxt;
    logic        cmp_q, res_q, inv_q;
    logic [IDX_W-1:0] idx_q;

    fcmp_decode i_decode (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar p = 0; p < N_PREC; p++) begin : g_prec
        localparam int E = (p == 0) ? EXP_SGL : EXP_DBL;
        localparam int M = (p == 0) ? MAN_SGL : MAN_DBL;
        localparam int PW = 1 + E + M;
        fcmp_relate #(.EXP_W(E), .MAN_W(M)) i_relate (
            .a        (opnd_a[PW-1:0]),
            .b        (opnd_b[PW-1:0]),
            .rel      (rel_p[p]),
            .any_nan  (nan_p[p]),
            .any_snan (snan_p[p])
        );
    end

    always_comb begin
        rel_sel = dec.dbl ? rel_p[1] : rel_p[0];
        hit     = dec.accept[rel_sel];
        if (dec.sig) inv = dec.dbl ? nan_p[1]  : nan_p[0];
        else         inv = dec.dbl ? snan_p[1] : snan_p[0];
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_EMIT : ST_IDLE;  // take
            ST_EMIT: state_nxt = in_valid ? ST_EMIT : ST_IDLE;  // chain / drain
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            res_q <= 1'b0;
            inv_q <= 1'b0;
            idx_q <= '0;
        end else if (in_valid) begin
            cmp_q <= dec.is_cmp;
            res_q <= dec.is_cmp & hit;
            inv_q <= dec.is_cmp & inv;
            idx_q <= dec.idx;
        end
    end

    assign out_wen      = (state == ST_EMIT) && cmp_q;
    assign out_invalid  = (state == ST_EMIT) && inv_q;
    assign out_result   = res_q;
    assign out_flag_idx = idx_q;

endmodule

// File: rtl/fcmp_flag_chk.sv
module fcmp_flag_chk
    import fcmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic              out_wen,
    input logic [IDX_W-1:0]  out_flag_idx,
    input logic              out_result,
    input logic              out_invalid
);

    logic opc_ok;
    assign opc_ok = (instr[31:20] == OPC_SGL) || (instr[31:20] == OPC_DBL);

    assert_wen_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> $past(in_valid));

    assert_gap_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> ($past(instr[4:3]) == 2'b00));

    assert_idx_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> (out_flag_idx == $past(instr[IDX_W-1:0])));

    assert_invalid_with_wen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_wen);

    assert_full_mask_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc_ok && (instr[4:3] == 2'b00) && (instr[19:16] == 4'hF))
        |=> (out_wen && out_result));

    assert_empty_mask_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (instr[19:16] == 4'h0)) |=> !out_result);

endmodule

bind fp_cmp_flag fcmp_flag_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .instr        (instr),
    .out_wen      (out_wen),
    .out_flag_idx (out_flag_idx),
    .out_result   (out_result),
    .out_invalid  (out_invalid)
);

// File: tb/test_fp_cmp_flag.sv
module test_fp_cmp_flag;
    import fcmp_pkg::*;

    typedef struct {
        logic       wen;
        logic [2:0] idx;
        logic       res;
        logic       inv;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        out_wen, out_result, out_invalid;
    logic [2:0]  out_flag_idx;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    fp_cmp_flag i_fp_cmp_flag (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_wen(out_wen),
        .out_flag_idx(out_flag_idx), .out_result(out_result),
        .out_invalid(out_invalid)
    );

    // independent reference: ordered integer keys
    function automatic logic [1:0] model(bit dbl, logic [4:0] cond,
                                         logic [63:0] a, logic [63:0] b);
        logic an, bn, asn, bsn, sa, sb, r, iv;
        logic [62:0] ma, mb;
        logic [63:0] ka, kb;
        int rel;
        if (dbl) begin
            an = (a[62:52] == 11'h7FF) && (a[51:0] != 0); asn = an && !a[51];
            bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0); bsn = bn && !b[51];
            ma = a[62:0]; mb = b[62:0]; sa = a[63]; sb = b[63];
        end else begin
            an = (a[30:23] == 8'hFF) && (a[22:0] != 0); asn = an && !a[22];
            bn = (b[30:23] == 8'hFF) && (b[22:0] != 0); bsn = bn && !b[22];
            ma = {32'b0, a[30:0]}; mb = {32'b0, b[30:0]}; sa = a[31]; sb = b[31];
        end
        ka = sa ? {1'b0, ~ma} : {1'b1, ma};
        kb = sb ? {1'b0, ~mb} : {1'b1, mb};
        if (an || bn)                  rel = 3;
        else if (ma == 0 && mb == 0)   rel = 1;
        else if (ka < kb)              rel = 0;
        else if (ka == kb)             rel = 1;
        else                           rel = 2;
        case (rel)
            0:       r = cond[1] | cond[4];
            1:       r = cond[2];
            2:       r = cond[4];
            default: r = cond[3];
        endcase
        iv = cond[0] ? (an | bn) : (asn | bsn);
        return {r, iv};
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_cmp(bit dbl, logic [4:0] cond, logic [2:0] idx,
                          logic [63:0] a, logic [63:0] b, string req);
        exp_t e;
        logic [1:0] m;
        m = model(dbl, cond, a, b);
        @(negedge clk);
        instr    = {dbl ? OPC_DBL : OPC_SGL, cond, 5'd2, 5'd1, 2'b00, idx};
        opnd_a   = a;
        opnd_b   = b;
        in_valid = 1'b1;
        e.wen = 1'b1; e.idx = idx; e.res = m[1]; e.inv = m[0]; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic do_raw(logic [31:0] w, string req);
        exp_t e;
        @(negedge clk);
        instr    = w;
        opnd_a   = 64'h7FF0_0000_0000_0001;
        opnd_b   = 64'h7FF0_0000_0000_0001;
        in_valid = 1'b1;
        e.wen = 1'b0; e.idx = 3'd0; e.res = 1'b0; e.inv = 1'b0; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops one expected item per sampled strobe
    initial begin
        exp_t e;
        bit v;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            v = in_valid;
            @(negedge clk);
            if (v) begin
                e = sb_q.pop_front();
                check(e.req, "wen", {7'b0, out_wen}, {7'b0, e.wen});
                check("R11", "inv", {7'b0, out_invalid}, {7'b0, e.inv});
                if (e.wen) begin
                    check("R3", "idx", {5'b0, out_flag_idx}, {5'b0, e.idx});
                    check(e.req, "res", {7'b0, out_result}, {7'b0, e.res});
                end
            end else begin
                check("R2", "idle wen", {7'b0, out_wen}, 8'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "wen", {7'b0, out_wen}, 8'h0);
        check("R12", "res", {7'b0, out_result}, 8'h0);
        check("R12", "inv", {7'b0, out_invalid}, 8'h0);
        check("R12", "idx", {5'b0, out_flag_idx}, 8'h0);
        rst_n = 1'b1;
        idle(2);

        // R4 / R7 single
        do_cmp(0, 5'b00010, 3'd1, 64'h3F80_0000, 64'h4000_0000, "R4");
        do_cmp(0, 5'b00100, 3'd2, 64'h3F80_0000, 64'h4000_0000, "R4");
        do_cmp(0, 5'b10000, 3'd3, 64'hBF80_0000, 64'hC000_0000, "R7");
        do_cmp(0, 5'b00010, 3'd4, 64'hBF80_0000, 64'hC000_0000, "R7");
        do_cmp(0, 5'b00010, 3'd5, 64'hC000_0000, 64'h3F80_0000, "R7");
        do_cmp(0, 5'b00010, 3'd6, 64'h3F80_0000, 64'h7F80_0000, "R7");
        idle(1);
        // R6 zeros
        do_cmp(0, 5'b00100, 3'd0, 64'h0000_0000, 64'h8000_0000, "R6");
        do_cmp(0, 5'b10000, 3'd0, 64'h8000_0000, 64'h0000_0000, "R6");
        do_cmp(1, 5'b00100, 3'd7, 64'h8000_0000_0000_0000, 64'h0, "R6");
        // R5 / R9 / R8 NaN handling
        do_cmp(0, 5'b01000, 3'd1, 64'h7FC0_0000, 64'h3F80_0000, "R5");
        do_cmp(0, 5'b10110, 3'd1, 64'h7FC0_0000, 64'h3F80_0000, "R5");
        do_cmp(0, 5'b00100, 3'd2, 64'h3F80_0000, 64'h7F80_0001, "R9");
        do_cmp(0, 5'b00101, 3'd2, 64'h7FC0_0000, 64'h3F80_0000, "R8");
        do_cmp(1, 5'b01000, 3'd3, 64'h7FF8_0000_0000_0000, 64'h7FF8_0000_0000_0000, "R5");
        do_cmp(1, 5'b00000, 3'd3, 64'h7FF0_0000_0000_0001, 64'h0, "R9");
        do_cmp(1, 5'b00011, 3'd4, 64'h7FF8_0000_0000_0000, 64'h0, "R8");
        idle(1);
        // double ordering
        do_cmp(1, 5'b10000, 3'd5, 64'h4008_0000_0000_0000, 64'hC014_0000_0000_0000, "R7");
        do_cmp(1, 5'b00010, 3'd5, 64'h4008_0000_0000_0000, 64'hC014_0000_0000_0000, "R7");
        do_cmp(1, 5'b00010, 3'd6, 64'hC014_0000_0000_0000, 64'hC008_0000_0000_0000, "R7");
        // R10 upper bits ignored in single
        do_cmp(0, 5'b00100, 3'd6, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_3F80_0000, "R10");
        do_cmp(0, 5'b00100, 3'd6, 64'h7FF8_0000_3F80_0000, 64'h1234_5678_3F80_0000, "R10");
        // mask extremes
        do_cmp(0, 5'b11111, 3'd7, 64'h7F80_0001, 64'h0, "R4");
        do_cmp(0, 5'b00001, 3'd7, 64'h3F80_0000, 64'h3F80_0000, "R4");
        // R3 every index
        for (int k = 0; k < 8; k++)
            do_cmp(0, 5'b00100, k[2:0], 64'h4000_0000, 64'h4000_0000, "R3");
        // R1 non-compare words
        do_raw({12'b0000_1100_0011, 5'b11111, 10'd0, 2'b00, 3'd1}, "R1");
        do_raw({12'b0000_1100_0001, 5'b11111, 10'd0, 2'b01, 3'd1}, "R1");
        do_raw({12'b0000_1100_0010, 5'b11111, 10'd0, 2'b10, 3'd1}, "R1");
        do_raw(32'h0000_0000, "R1");
        do_cmp(1, 5'b00101, 3'd2, 64'h7FF0_0000_0000_0001, 64'h0, "R11");
        idle(4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule